// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block rebuilds the three classic real-time-clock interrupt sources (update, alarm and periodic) on top of a single one-shot comparator channel of a free-running counter. The comparator fires at a fixed base polling rate of 64 per second, or faster when a fast periodic rate is requested. On every comparator tick the block moves the comparator value forward by the active delta. It keeps stepping until the comparator is ahead of the live counter again. Each step beyond the first is counted as a lost tick.

After re-arming, the block looks at the time of day supplied from outside (hour, minute, second) and decides which flags to raise. The update flag is raised on a change of the seconds value. The periodic flag is raised after a programmable number of ticks. The alarm flag is raised on a match with a programmed alarm time; as a compatibility quirk, the alarm is only evaluated while the periodic source is enabled. When any flag is raised, the block emits a one-cycle interrupt pulse together with a flag word. Software-side clock keeping and calendar arithmetic stay outside.

Enables, alarm time and periodic rate are written through a simple write-enable port selected by `cfg_sel`. `DEF_DELTA` is the number of counter ticks in one 64th of a second.

Top module: `rtc_irq_emu`

## Requirements
- R1: A write with `cfg_sel`=0 sets the enables from `cfg_wdata[2:0]`: bit 0 is update, bit 1 is alarm, bit 2 is periodic. If no source was enabled before and at least one is enabled by the write, the comparator is loaded with `cnt_now` plus the active delta and `cmp_en` goes high at that edge. A write while some source is already enabled leaves `cmp_val` unchanged.
- R2: A write with `cfg_sel`=2 takes a power-of-two rate in Hz from `cfg_wdata[13:0]`. A rate of 64 or less sets the divider limit to 64 divided by the rate, and the active delta is `DEF_DELTA`. A higher rate sets the limit to 0 and, while the periodic source is enabled, makes the active delta `DEF_DELTA`*64/rate. A rate of 0 is ignored. After reset the limit is 1.
- R3: On a `tick_i` while `cmp_en` is high and a source is enabled, `cmp_val` is advanced by the delta once per cycle until `cnt_now - cmp_val` is no longer positive as a signed value. Each step after the first is a lost tick, and the count is shown on `lost_o`. The evaluation result appears on `irq_o` k+2 cycles after the tick edge, where k is the lost count.
- R4: While the periodic source is enabled, the lost ticks of a tick are added to the periodic divider count before it is incremented.
- R5: With update enabled, flag bit 4 is raised when `tod_sec` differs from the seconds value stored at the last update, and the new value is then stored. The stored value is 0 after reset.
- R6: With periodic enabled, flag bit 6 is raised when the incremented divider count reaches the limit, and the count then returns to zero.
- R7: Flag bit 5 (alarm) is raised when hour, minute and second equal the alarm written with `cfg_sel`=1 (`cfg_wdata[23:16]` hour, `[15:8]` minute, `[7:0]` second). This happens only when the periodic enable is set, regardless of the alarm enable.
- R8: When any flag is raised, `irq_o` pulses for exactly one cycle, and for that cycle `irq_word` carries the flags plus bit 7 set and the value 1 in bits 15:8. At all other times `irq_word` is 0.
- R9: A tick that arrives with all enables clear drops `cmp_en`, leaves `cmp_val` unchanged and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_now | input | CW | Live value of the free-running counter |
| tick_i | input | 1 | Comparator match pulse |
| tod_hour | input | 8 | Current hour |
| tod_min | input | 8 | Current minute |
| tod_sec | input | 8 | Current second |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 enables, 1 alarm, 2 rate |
| cfg_wdata | input | 24 | Configuration write data |
| cmp_val | output | CW | Comparator value to program |
| cmp_en | output | 1 | Comparator channel enable |
| irq_o | output | 1 | One-cycle interrupt pulse |
| irq_word | output | 16 | Flag word valid with irq_o |
| lost_o | output | LW | Lost ticks of the latest re-arm |

## Verification
A wrong divider count or a stale seconds register does not show at once. It shows as a missing or extra interrupt pulse on the tick where the periodic or update decision goes the other way, which can be several ticks after the faulty step. A wrong comparator step shows at once on `cmp_val`, and it also moves the pulse latency and the `lost_o` value of the same tick. The directed scenarios therefore check `cmp_val`, the latency and `lost_o` on every tick, and they run the periodic divider through complete wraps so that a count error shows up within the next period.

// File: rtl/rtc_emu_pkg.sv
// Package: shared encodings for the RTC interrupt emulation engine.
// Assumes: enable and flag bit positions are fixed by the requirements.
package rtc_emu_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_EVAL = 2'd2
    } phase_t;

    localparam int EN_UPD = 0;
    localparam int EN_ALM = 1;
    localparam int EN_PER = 2;

    localparam logic [7:0] FLG_UPD = 8'h10;
    localparam logic [7:0] FLG_ALM = 8'h20;
    localparam logic [7:0] FLG_PER = 8'h40;
    localparam logic [7:0] FLG_IRQ = 8'h80;

    localparam logic [1:0] SEL_EN   = 2'd0;
    localparam logic [1:0] SEL_ALM  = 2'd1;
    localparam logic [1:0] SEL_RATE = 2'd2;

    localparam int BASE_HZ_LG = 6;
endpackage

// File: rtl/rtc_rate_cfg.sv
// Module: configuration registers (enables, alarm time, periodic rate).
// Derives the divider limit and the fast delta from a power-of-two rate,
// picks the active delta, and flags the arming condition on an enable write.
// Assumes: rate values are powers of two; non power-of-two rates use their top bit.
module rtc_rate_cfg
    import rtc_emu_pkg::*;
#(
    parameter int CW = 32,
    parameter logic [CW-1:0] DEF_DELTA = 32'd262144,
    parameter int RW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [23:0]   cfg_wdata,
    output logic [2:0]    en_o,
    output logic [7:0]    alm_hour_o,
    output logic [7:0]    alm_min_o,
    output logic [7:0]    alm_sec_o,
    output logic [6:0]    lim_o,
    output logic [CW-1:0] delta_o,
    output logic          arm_o,
    output logic [CW-1:0] arm_delta_o
);
    localparam int LGW = $clog2(RW) + 1;

    logic [2:0]    en_q;
    logic [6:0]    lim_q;
    logic [CW-1:0] fast_q;
    logic [RW-1:0] rate_w;
    logic [LGW-1:0] rate_lg;

    // Highest set bit of the requested rate.
    always_comb begin
        rate_lg = '0;
        for (int i = 0; i < RW; i++) begin
            if (rate_w[i]) rate_lg = LGW'(i);
        end
    end

    assign rate_w = cfg_wdata[RW-1:0];

    // Register updates for the three write targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            alm_hour_o <= '0;
            alm_min_o  <= '0;
            alm_sec_o  <= '0;
            lim_q      <= 7'd1;
            fast_q     <= DEF_DELTA;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_EN: en_q <= cfg_wdata[2:0];
                SEL_ALM: begin
                    alm_hour_o <= cfg_wdata[23:16];
                    alm_min_o  <= cfg_wdata[15:8];
                    alm_sec_o  <= cfg_wdata[7:0];
                end
                SEL_RATE: begin
                    if (rate_w != '0) begin
                        if (rate_lg <= LGW'(BASE_HZ_LG)) begin
                            lim_q <= 7'd64 >> rate_lg;
                        end else begin
                            lim_q  <= 7'd0;
                            fast_q <= DEF_DELTA >> (rate_lg - LGW'(BASE_HZ_LG));
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Active delta and arming decision.
    always_comb begin
        delta_o     = (en_q[EN_PER] && lim_q == 7'd0) ? fast_q : DEF_DELTA;
        arm_o       = cfg_we && cfg_sel == SEL_EN && en_q == 3'd0 && cfg_wdata[2:0] != 3'd0;
        arm_delta_o = (cfg_wdata[EN_PER] && lim_q == 7'd0) ? fast_q : DEF_DELTA;
    end

    assign en_o  = en_q;
    assign lim_o = lim_q;

    // R2
    lim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q <= 7'd64);
endmodule

// File: rtl/rtc_rearm.sv
// Module: comparator re-arm with catch-up over missed ticks.
// On a tick it steps the comparator by the delta, one step per cycle, until
// the comparator is ahead of the live counter; extra steps are lost ticks.
// Assumes: cnt_now is a wrapping counter compared with signed differences.
module rtc_rearm
    import rtc_emu_pkg::*;
#(
    parameter int CW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_now,
    input  logic          tick_i,
    input  logic          en_any_i,
    input  logic [CW-1:0] delta_i,
    input  logic          arm_i,
    input  logic [CW-1:0] arm_delta_i,
    output logic [CW-1:0] cmp_val_o,
    output logic          cmp_en_o,
    output logic          eval_o,
    output logic [LW-1:0] lost_o
);
    phase_t        phase_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cmp_nxt;
    logic          behind;
    logic [LW-1:0] extra_q;

    // Candidate next comparator value and lateness test.
    always_comb begin
        cmp_nxt = cmp_q + delta_i;
        behind  = $signed(cnt_now - cmp_nxt) > 0;
    end

    // Phase sequencer, comparator register and lost-tick tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cmp_q    <= '0;
            cmp_en_o <= 1'b0;
            extra_q  <= '0;
            lost_o   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (tick_i && cmp_en_o) begin
                        if (en_any_i) begin
                            phase_q <= PH_STEP;
                            extra_q <= '0;
                        end else begin
                            cmp_en_o <= 1'b0;
                        end
                    end
                end
                PH_STEP: begin
                    cmp_q <= cmp_nxt;
                    if (behind) begin
                        if (extra_q != '1) extra_q <= extra_q + 1'b1;
                    end else begin
                        lost_o  <= extra_q;
                        phase_q <= PH_EVAL;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
            if (arm_i) begin
                cmp_q    <= cnt_now + arm_delta_i;
                cmp_en_o <= 1'b1;
            end
        end
    end

    assign cmp_val_o = cmp_q;
    assign eval_o    = (phase_q == PH_EVAL);

    // R3
    eval_from_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EVAL) |-> ($past(phase_q) == PH_STEP));
endmodule

// File: rtl/rtc_flag_gen.sv
// Module: flag generation for update, periodic and alarm sources.
// Evaluates once per re-armed tick and emits the flag word with an IRQ pulse.
// Assumes: eval_i is a single-cycle strobe issued after the re-arm settles.
module rtc_flag_gen
    import rtc_emu_pkg::*;
#(
    parameter int LW = 8,
    parameter int PCW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval_i,
    input  logic [2:0]    en_i,
    input  logic [7:0]    tod_hour,
    input  logic [7:0]    tod_min,
    input  logic [7:0]    tod_sec,
    input  logic [7:0]    alm_hour,
    input  logic [7:0]    alm_min,
    input  logic [7:0]    alm_sec,
    input  logic [6:0]    lim_i,
    input  logic [LW-1:0] lost_i,
    output logic          irq_o,
    output logic [15:0]   irq_word
);
    logic [PCW-1:0] pcnt_q;
    logic [PCW:0]   pcnt_sum;
    logic [PCW-1:0] pcnt_nxt;
    logic [7:0]     prev_sec_q;
    logic           upd_hit, per_hit, alm_hit;
    logic [7:0]     flags;

    // Source decisions for the current evaluation.
    always_comb begin
        pcnt_sum = {1'b0, pcnt_q} + (PCW+1)'(lost_i) + 1'b1;
        pcnt_nxt = pcnt_sum[PCW] ? '1 : pcnt_sum[PCW-1:0];
        upd_hit  = en_i[EN_UPD] && (tod_sec != prev_sec_q);
        per_hit  = en_i[EN_PER] && (pcnt_nxt >= PCW'(lim_i));
        alm_hit  = en_i[EN_PER] && tod_hour == alm_hour &&
                   tod_min == alm_min && tod_sec == alm_sec;
        flags    = (upd_hit ? FLG_UPD : 8'h00) | (per_hit ? FLG_PER : 8'h00) |
                   (alm_hit ? FLG_ALM : 8'h00);
    end

    // Divider count and stored seconds, updated on evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q     <= '0;
            prev_sec_q <= '0;
        end else if (eval_i) begin
            if (upd_hit) prev_sec_q <= tod_sec;
            if (en_i[EN_PER]) pcnt_q <= per_hit ? '0 : pcnt_nxt;
        end
    end

    // Output pulse and word, zero outside the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o    <= 1'b0;
            irq_word <= '0;
        end else if (eval_i && flags != 8'h00) begin
            irq_o    <= 1'b1;
            irq_word <= {8'd1, flags | FLG_IRQ};
        end else begin
            irq_o    <= 1'b0;
            irq_word <= '0;
        end
    end

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R8
    irq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_word[15:8] == 8'd1 && irq_word[7] && irq_word[6:4] != 3'd0));
endmodule

// File: rtl/rtc_irq_emu.sv
// Module: top of the RTC interrupt emulation engine.
// Ties configuration, comparator re-arm and flag generation together.
// Assumes: tick_i pulses when the external comparator matches cmp_val.
module rtc_irq_emu
    import rtc_emu_pkg::*;
#(
    parameter int CW = 32,
    parameter logic [CW-1:0] DEF_DELTA = 32'd262144,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_now,
    input  logic          tick_i,
    input  logic [7:0]    tod_hour,
    input  logic [7:0]    tod_min,
    input  logic [7:0]    tod_sec,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [23:0]   cfg_wdata,
    output logic [CW-1:0] cmp_val,
    output logic          cmp_en,
    output logic          irq_o,
    output logic [15:0]   irq_word,
    output logic [LW-1:0] lost_o
);
    logic [2:0]    en;
    logic [7:0]    alm_h, alm_m, alm_s;
    logic [6:0]    lim;
    logic [CW-1:0] delta, arm_delta;
    logic          arm, eval;

    rtc_rate_cfg #(.CW(CW), .DEF_DELTA(DEF_DELTA)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .en_o(en), .alm_hour_o(alm_h), .alm_min_o(alm_m),
        .alm_sec_o(alm_s), .lim_o(lim), .delta_o(delta), .arm_o(arm),
        .arm_delta_o(arm_delta)
    );

    rtc_rearm #(.CW(CW), .LW(LW)) u_rearm (
        .clk(clk), .rst_n(rst_n), .cnt_now(cnt_now), .tick_i(tick_i),
        .en_any_i(en != 3'd0), .delta_i(delta), .arm_i(arm),
        .arm_delta_i(arm_delta), .cmp_val_o(cmp_val), .cmp_en_o(cmp_en),
        .eval_o(eval), .lost_o(lost_o)
    );

    rtc_flag_gen #(.LW(LW)) u_flags (
        .clk(clk), .rst_n(rst_n), .eval_i(eval), .en_i(en),
        .tod_hour(tod_hour), .tod_min(tod_min), .tod_sec(tod_sec),
        .alm_hour(alm_h), .alm_min(alm_m), .alm_sec(alm_s), .lim_i(lim),
        .lost_i(lost_o), .irq_o(irq_o), .irq_word(irq_word)
    );

    // R9
    no_irq_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> !irq_o);
endmodule

// File: tb/sim_rtc_irq_emu.sv
// Directed bench for rtc_irq_emu: one task per scenario.
module sim_rtc_irq_emu;
    localparam int CW = 32;
    localparam int LW = 8;
    localparam logic [31:0] DD = 32'd64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt_now = '0;
    logic          tick_i = 1'b0;
    logic [7:0]    tod_hour = '0, tod_min = '0, tod_sec = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [23:0]   cfg_wdata = '0;
    logic [CW-1:0] cmp_val;
    logic          cmp_en;
    logic          irq_o;
    logic [15:0]   irq_word;
    logic [LW-1:0] lost_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_irq_emu #(.CW(CW), .DEF_DELTA(DD), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_now(cnt_now), .tick_i(tick_i),
        .tod_hour(tod_hour), .tod_min(tod_min), .tod_sec(tod_sec),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cmp_val(cmp_val), .cmp_en(cmp_en), .irq_o(irq_o),
        .irq_word(irq_word), .lost_o(lost_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one tick with the counter at cnt; expect irq after k+2 edges when exp_irq.
    task automatic tick_at(input string req, input logic [CW-1:0] cnt, input bit exp_irq,
                           input logic [15:0] exp_word, input int exp_lost,
                           input logic [CW-1:0] exp_cmp);
        int lat;
        logic [15:0] word;
        logic [LW-1:0] lost;
        lat = 0; word = '0; lost = '0;
        @(negedge clk);
        cnt_now = cnt; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (irq_o && lat == 0) begin
                lat = i; word = irq_word; lost = lost_o;
            end
        end
        if (exp_irq) begin
            chk(req, "irq latency", lat, exp_lost + 2);
            chk(req, "irq word", word, exp_word);
            chk("R3", "lost count", lost, exp_lost);
        end else begin
            chk(req, "no irq", lat, 0);
        end
        chk(req, "cmp_val", cmp_val, exp_cmp);
    endtask

    task automatic t_reset;
        chk("R8", "reset irq", irq_o, 0);
        chk("R8", "reset word", irq_word, 0);
        chk("R1", "reset cmp_en", cmp_en, 0);
    endtask

    task automatic t_update;
        logic [CW-1:0] c;
        cnt_now = 32'd1000;
        cfg_write(2'd0, 24'h000001);
        chk("R1", "arm cmp_val", cmp_val, 1064);
        chk("R1", "arm cmp_en", cmp_en, 1);
        tod_sec = 8'd5;
        tick_at("R5", 32'd1064, 1'b1, 16'h0190, 0, 32'd1128);
        tick_at("R5", 32'd1128, 1'b0, 16'h0, 0, 32'd1192);
        tod_sec = 8'd6;
        c = cmp_val;
        tick_at("R3", c + 3*64 + 10, 1'b1, 16'h0190, 3, c + 4*64);
    endtask

    task automatic t_disable;
        logic [CW-1:0] c;
        cfg_write(2'd0, 24'h000000);
        c = cmp_val;
        tick_at("R9", c, 1'b0, 16'h0, 0, c);
        chk("R9", "cmp_en dropped", cmp_en, 0);
    endtask

    task automatic t_periodic;
        logic [CW-1:0] c;
        cfg_write(2'd2, 24'd16);
        cnt_now = 32'd5000;
        cfg_write(2'd0, 24'h000004);
        chk("R1", "re-arm cmp_val", cmp_val, 5064);
        for (int n = 1; n <= 3; n++) begin
            c = cmp_val;
            tick_at("R6", c, 1'b0, 16'h0, 0, c + 64);
        end
        c = cmp_val;
        tick_at("R6", c, 1'b1, 16'h01C0, 0, c + 64);
        c = cmp_val;
        tick_at("R4", c + 2*64 + 1, 1'b0, 16'h0, 2, c + 3*64);
        c = cmp_val;
        tick_at("R4", c, 1'b1, 16'h01C0, 0, c + 64);
    endtask

    task automatic t_alarm;
        logic [CW-1:0] c;
        cfg_write(2'd2, 24'd64);
        cfg_write(2'd1, 24'h0A0B0C);
        tod_hour = 8'h0A; tod_min = 8'h0B; tod_sec = 8'h0C;
        cfg_write(2'd0, 24'h000002);
        c = cmp_val;
        tick_at("R7", c, 1'b0, 16'h0, 0, c + 64);
        cfg_write(2'd0, 24'h000006);
        chk("R1", "no re-arm when enabled", cmp_val, c + 64);
        c = cmp_val;
        tick_at("R7", c, 1'b1, 16'h01E0, 0, c + 64);
    endtask

    task automatic t_fast;
        logic [CW-1:0] c;
        tod_sec = 8'h00;
        cfg_write(2'd2, 24'd256);
        c = cmp_val;
        tick_at("R2", c, 1'b1, 16'h01C0, 0, c + 16);
        cfg_write(2'd2, 24'd0);
        c = cmp_val;
        tick_at("R2", c, 1'b1, 16'h01C0, 0, c + 16);
        cfg_write(2'd2, 24'd2);
        c = cmp_val;
        tick_at("R2", c, 1'b0, 16'h0, 0, c + 64);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_update;
        t_disable;
        t_periodic;
        t_alarm;
        t_fast;
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule